// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Bus

This block is a target on an SMBus-style two-wire bus that holds a bank of 8-bit configuration registers. A host changes the bank with an indexed block write: the slave address for writing, a starting index, a byte count, and then the data bytes. It reads the bank back with an indexed block read: the write address and the index, a repeated start, and the read address. The slave then returns a length byte followed by the registers from the index onward. The index increments after every data byte in both directions.

Clock and data arrive as plain inputs. The slave pulls the data line low through a drive-enable output, so the board supplies the wired-AND. It does not stretch the clock. Each line passes through a two-stage synchroniser and a majority-free deglitch filter before start, stop and bit edges are extracted. Every change the slave makes on the data line happens while the clock is low.

The bank appears in parallel as a flat vector. One register carries a read-only field that holds five strap inputs, captured while reset is held. A second register selects whether the five-bit frequency code comes from those straps or from software bits, and it carries a spread-enable bit. A third register sets the length byte returned by block reads.

Top module: `smb_block_slave`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address byte the slave leaves SDA released for the rest of the transfer, until the next start, and no register changes.
- R2: In a block write (start, 0xD2, index N, count X, data), every byte is acknowledged, and data byte k (k < X) is stored in register N+k. Bytes are sent MSB first, with the ACK driven low on the ninth clock.
- R3: Data bytes beyond the count X of a block write are acknowledged and discarded.
- R4: Writes to an index at or above NUM_REGS (default 16) are acknowledged and discarded, and reads of such an index return 0x00.
- R5: In a block read, the first byte the slave returns is the current value of register 8. It then returns registers N, N+1, and so on for as long as the host acknowledges.
- R6: After the host answers a byte with a not-acknowledge (SDA high on the ninth clock), the slave drives SDA no further until the next start.
- R7: After reset, register 4 is 0x04, register 8 is 0x0F, register 5 bits 7:5 are 1, all other registers are 0x00, and SDA is released.
- R8: Register 5 bits 4:0 hold strapFs as sampled while rstN is low. Bus writes to those bits, and later changes of strapFs, leave them unchanged. Writes to bits 7:5 take effect.
- R9: With register 4 bit 3 at 0, fsActive equals register 5 bits 4:0. With it at 1, fsActive is {register 4 bits 7:4, register 4 bit 0}. spreadEn always follows register 4 bit 2.
- R10: sdaOe changes only while SCL is low.
- R11: A pulse on SCL shorter than FILT_LEN clock cycles is not taken as a bit clock.
- R12: A repeated start is accepted in place of a stop and start, and the index set before it is kept for the read that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while low |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | When high, the slave pulls SDA low |
| strapFs | input | 5 | Frequency-select strap levels |
| regFlat | output | NUM_REGS*8 | Register bank; register i at bits i*8+7:i*8 |
| fsActive | output | 5 | Frequency code selected from straps or software |
| spreadEn | output | 1 | Spread-enable bit from register 4 |

## Verification
The bench goes after the edges of the byte sequence. It sends data bytes past the count, where a slave that ignored the count would overwrite neighbouring registers. It writes across the end of the bank, where a slave that wrapped or failed to acknowledge would corrupt register 0 or stall the host. It uses a foreign address, where a careless slave would acknowledge and store the following bytes. It checks the length byte after register 8 has been rewritten, and it checks the release after a not-acknowledge, where a slave that kept transmitting would hold SDA low into the stop. It writes into the strap field, changes the strap pins after reset, and injects a one-cycle SCL spike. A design that wrongly masked the field, re-sampled the pins, or counted the spike as a bit would show wrong register contents when compared against the model.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

  localparam int IDX_W  = 8;
  localparam int STRAP_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } busState_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_INDEX,
    ROLE_COUNT,
    ROLE_DATA
  } byteRole_t;

  // One-cycle strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       setIndex;
    logic       setCount;
    logic       wrData;
    logic       txData;
    logic [7:0] rxByte;
  } ctrlStrobe_t;

endpackage

// File: rtl/smbx_deglitch.sv
module smbx_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic clean,
  output logic rise,
  output logic fall
);
  logic [1:0]          syncQ;
  logic [FILT_LEN-1:0] hist;
  logic                cleanD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '1;
      hist   <= '1;
      clean  <= 1'b1;
      cleanD <= 1'b1;
    end else begin
      syncQ  <= {syncQ[0], rawIn};
      hist   <= {hist[FILT_LEN-2:0], syncQ[1]};
      if (&hist)       clean <= 1'b1;
      else if (~|hist) clean <= 1'b0;
      cleanD <= clean;
    end
  end

  assign rise = clean & ~cleanD;
  assign fall = ~clean & cleanD;

endmodule

// File: rtl/smbx_ctrl.sv
module smbx_ctrl
  import smbx_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         FILT_LEN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rdByte,
  input  logic [7:0]  countByte,
  output logic        sdaOe,
  output ctrlStrobe_t stb,
  output busState_t   busState
);
  logic sclF, sclRise, sclFall;
  logic sdaF, sdaRise, sdaFall;

  smbx_deglitch #(.FILT_LEN(FILT_LEN)) uSclFilt (
    .clk(clk), .rstN(rstN), .rawIn(sclIn),
    .clean(sclF), .rise(sclRise), .fall(sclFall)
  );
  smbx_deglitch #(.FILT_LEN(FILT_LEN)) uSdaFilt (
    .clk(clk), .rstN(rstN), .rawIn(sdaIn),
    .clean(sdaF), .rise(sdaRise), .fall(sdaFall)
  );

  logic startDet, stopDet;
  assign startDet = sdaFall & sclF;
  assign stopDet  = sdaRise & sclF;

  busState_t  state;
  byteRole_t  role;
  logic       rw;
  logic       ackd;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       sdaDrive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      role     <= ROLE_ADDR;
      rw       <= 1'b0;
      ackd     <= 1'b0;
      bitCnt   <= '0;
      shReg    <= '0;
      sdaDrive <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (startDet) begin
        state    <= ST_RX;
        role     <= ROLE_ADDR;
        bitCnt   <= '0;
        sdaDrive <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        sdaDrive <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (role == ROLE_ADDR && shReg[7:1] != ADDR7) begin
                state <= ST_IGNORE;
              end else begin
                sdaDrive   <= 1'b1;
                state      <= ST_RXACK;
                stb.rxByte <= shReg;
                case (role)
                  ROLE_ADDR:  rw           <= shReg[0];
                  ROLE_INDEX: stb.setIndex <= 1'b1;
                  ROLE_COUNT: stb.setCount <= 1'b1;
                  default:    stb.wrData   <= 1'b1;
                endcase
              end
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (role == ROLE_ADDR && rw) begin
                shReg    <= countByte;
                sdaDrive <= ~countByte[7];
                state    <= ST_TX;
              end else begin
                sdaDrive <= 1'b0;
                state    <= ST_RX;
                case (role)
                  ROLE_ADDR:  role <= ROLE_INDEX;
                  ROLE_INDEX: role <= ROLE_COUNT;
                  default:    role <= ROLE_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaDrive <= 1'b0;
                state    <= ST_TXACK;
              end else begin
                bitCnt   <= bitCnt + 4'd1;
                shReg    <= {shReg[6:0], 1'b0};
                sdaDrive <= ~shReg[6];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              ackd <= ~sdaF;
            end else if (sclFall) begin
              if (ackd) begin
                shReg      <= rdByte;
                sdaDrive   <= ~rdByte[7];
                bitCnt     <= '0;
                state      <= ST_TX;
                stb.txData <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe    = sdaDrive;
  assign busState = state;

endmodule

// File: rtl/smbx_regbank.sv
module smbx_regbank
  import smbx_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         CFG_REG     = 4,
  parameter int         STRAP_REG   = 5,
  parameter int         COUNT_REG   = 8,
  parameter logic [7:0] COUNT_RESET = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STRAP_W-1:0]    strapFs,
  input  ctrlStrobe_t           stb,
  output logic [7:0]            rdByte,
  output logic [7:0]            countByte,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic [STRAP_W-1:0]    fsActive,
  output logic                  spreadEn
);
  localparam int SRC_BIT    = 3;
  localparam int SPREAD_BIT = 2;

  logic [IDX_W-1:0] idx;
  logic [7:0]       remain;
  logic             wrEn;

  assign wrEn = stb.wrData && (remain != 8'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx    <= '0;
      remain <= '0;
    end else if (stb.setIndex) begin
      idx <= stb.rxByte;
    end else if (stb.setCount) begin
      remain <= stb.rxByte;
    end else if (wrEn) begin
      idx    <= idx + 1'b1;
      remain <= remain - 8'd1;
    end else if (stb.txData) begin
      idx <= idx + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DFLT = (i == CFG_REG)   ? 8'h04 :
                                  (i == STRAP_REG) ? 8'hE0 :
                                  (i == COUNT_REG) ? COUNT_RESET : 8'h00;
    localparam logic [7:0] RO   = (i == STRAP_REG) ? 8'(2**STRAP_W - 1) : 8'h00;
    logic [7:0] val;
    logic [7:0] resetVal;

    if (i == STRAP_REG) begin : g_strap
      assign resetVal = DFLT | 8'(strapFs);
    end else begin : g_plain
      assign resetVal = DFLT;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        val <= resetVal;
      else if (wrEn && idx == IDX_W'(i))
        val <= (val & RO) | (stb.rxByte & ~RO);
    end
    assign regFlat[i*8 +: 8] = val;
  end

  always_comb begin
    rdByte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rdByte = regFlat[i*8 +: 8];
  end

  logic [7:0] cfgReg;
  assign cfgReg    = regFlat[CFG_REG*8 +: 8];
  assign countByte = regFlat[COUNT_REG*8 +: 8];
  assign spreadEn  = cfgReg[SPREAD_BIT];
  assign fsActive  = cfgReg[SRC_BIT] ? {cfgReg[7:4], cfgReg[0]}
                                     : regFlat[STRAP_REG*8 +: STRAP_W];

endmodule

// File: rtl/smb_block_slave.sv
module smb_block_slave
  import smbx_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         FILT_LEN    = 3,
  parameter int         CFG_REG     = 4,
  parameter int         STRAP_REG   = 5,
  parameter int         COUNT_REG   = 8,
  parameter logic [7:0] COUNT_RESET = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [4:0]            strapFs,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic [4:0]            fsActive,
  output logic                  spreadEn
);
  ctrlStrobe_t stb;
  busState_t   ctrlState;
  logic [7:0]  rdByte;
  logic [7:0]  countByte;

  smbx_ctrl #(.ADDR7(ADDR7), .FILT_LEN(FILT_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .countByte(countByte),
    .sdaOe(sdaOe), .stb(stb), .busState(ctrlState)
  );

  smbx_regbank #(
    .NUM_REGS(NUM_REGS), .CFG_REG(CFG_REG), .STRAP_REG(STRAP_REG),
    .COUNT_REG(COUNT_REG), .COUNT_RESET(COUNT_RESET)
  ) uBank (
    .clk(clk), .rstN(rstN), .strapFs(strapFs), .stb(stb),
    .rdByte(rdByte), .countByte(countByte), .regFlat(regFlat),
    .fsActive(fsActive), .spreadEn(spreadEn)
  );

endmodule

// File: rtl/smbx_checker.sv
module smbx_checker
  import smbx_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int STRAP_REG = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regFlat,
  input ctrlStrobe_t           stb,
  input busState_t             ctrlState
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= rstN;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !$stable(sdaOe) |-> !sclIn) else $error("sdaOe changed while SCL high"); // R10
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $stable(regFlat[STRAP_REG*8 +: STRAP_W])) else $error("strap field moved"); // R8
  AST_IGNORE_RELEASES: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (ctrlState == ST_IGNORE) |-> !sdaOe) else $error("drive while ignoring"); // R1
  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (ctrlState == ST_IDLE) |-> !sdaOe) else $error("drive while idle"); // R6
  AST_BANK_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !$stable(regFlat) |-> $past(stb.wrData)) else $error("bank changed unprompted"); // R2
  AST_ACK_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN || !armed)
    stb.wrData |-> sdaOe) else $error("data byte taken without ack"); // R3
endmodule

bind smb_block_slave smbx_checker #(.NUM_REGS(NUM_REGS), .STRAP_REG(STRAP_REG)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regFlat(regFlat), .stb(stb), .ctrlState(ctrlState)
);

// File: tb/tb_smb_block_slave.sv
module tb_smb_block_slave;
  localparam int NR = 16;
  localparam int Q  = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, sclH = 1'b1, sdaH = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic [4:0] strapLatched;
  wire  sdaOe, spreadEn;
  wire  [NR*8-1:0] regFlat;
  wire  [4:0] fsActive;
  wire  sdaBus = sdaH & ~sdaOe;

  smb_block_slave #(.NUM_REGS(NR)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclH), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapFs(strap), .regFlat(regFlat), .fsActive(fsActive), .spreadEn(spreadEn)
  );

  int compared = 0, mismatched = 0;
  bit cmpOn = 1'b0;
  logic [7:0] m [NR];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] roMask(input int i);
    return (i == 5) ? 8'h1F : 8'h00;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // reference model compared on every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmpOn) begin
      logic [NR*8-1:0] expFlat;
      logic [4:0] expFs;
      for (int i = 0; i < NR; i++) expFlat[i*8 +: 8] = m[i];
      compared++;
      if (regFlat !== expFlat) begin
        mismatched++;
        $display("FAIL bank R1 R2 R3 R4 R8 actual=0x%0h expected=0x%0h", regFlat, expFlat);
      end
      expFs = m[4][3] ? {m[4][7:4], m[4][0]} : strapLatched;
      check(fsActive == expFs, "R9 fsActive", fsActive, expFs);
      check(spreadEn == m[4][2], "R9 spreadEn", spreadEn, m[4][2]);
    end
  end

  task automatic bitOut(input bit b, input bit gl, output bit s);
    sdaH = b;
    wq(4);
    if (gl) begin sclH = 1'b1; wq(1); sclH = 1'b0; end
    wq(Q);
    sclH = 1'b1; wq(Q);
    s = sdaBus;
    wq(Q);
    sclH = 1'b0; wq(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit gl, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) bitOut(b[i], gl && i == 3, s);
    bitOut(1'b1, 1'b0, s);
    check(s == !expAck, req, s, !expAck);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin bitOut(1'b1, 1'b0, s); v[i] = s; end
    bitOut(nack, 1'b0, s);
  endtask

  task automatic startC();
    sdaH = 1'b1; sclH = 1'b1; wq(Q); sdaH = 1'b0; wq(Q); sclH = 1'b0; wq(Q);
  endtask
  task automatic repStart();
    sdaH = 1'b1; wq(Q); sclH = 1'b1; wq(Q); sdaH = 1'b0; wq(Q); sclH = 1'b0; wq(Q);
  endtask
  task automatic stopC();
    sdaH = 1'b0; wq(Q); sclH = 1'b1; wq(Q); sdaH = 1'b1; wq(2*Q);
  endtask

  task automatic blockWrite(input int idx, input int cnt, input logic [7:0] d[$], input bit gl);
    cmpOn = 1'b0;
    startC();
    sendByte(8'hD2, 1'b1, 1'b0, "R1 write address ack");
    sendByte(8'(idx), 1'b1, 1'b0, "R2 index ack");
    sendByte(8'(cnt), 1'b1, 1'b0, "R2 count ack");
    foreach (d[k]) begin
      sendByte(d[k], 1'b1, gl && k == 0,
               gl ? "R11 glitched byte ack" : (k >= cnt) ? "R3 extra byte ack" :
               (idx + k >= NR) ? "R4 beyond bank ack" : "R2 data ack");
      if (k < cnt && idx + k < NR)
        m[idx+k] = (m[idx+k] & roMask(idx+k)) | (d[k] & ~roMask(idx+k));
    end
    stopC();
    wq(4); cmpOn = 1'b1; wq(8);
  endtask

  task automatic blockRead(input int idx, input int n);
    logic [7:0] v;
    bit s;
    cmpOn = 1'b0;
    startC();
    sendByte(8'hD2, 1'b1, 1'b0, "R1 write address ack");
    sendByte(8'(idx), 1'b1, 1'b0, "R2 index ack");
    repStart();
    sendByte(8'hD3, 1'b1, 1'b0, "R12 read address after repeated start");
    recvByte(1'b0, v);
    check(v == m[8], "R5 length byte", v, m[8]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      recvByte(k == n - 1, v);
      e = (idx + k < NR) ? m[idx+k] : 8'h00;
      check(v == e, (idx + k >= NR) ? "R4 unimplemented read" : "R5 R12 data byte", v, e);
    end
    check(sdaOe == 1'b0, "R6 released after nack", sdaOe, 0);
    bitOut(1'b1, 1'b0, s);
    check(s == 1'b1, "R6 silent after nack", s, 1);
    stopC();
    wq(4); cmpOn = 1'b1; wq(8);
  endtask

  initial begin
    wq(5);
    for (int i = 0; i < NR; i++)
      m[i] = (i == 4) ? 8'h04 : (i == 5) ? (8'hE0 | 8'(strap)) : (i == 8) ? 8'h0F : 8'h00;
    strapLatched = strap;
    rstN = 1'b1;
    wq(2);
    strap = 5'b01001;
    check(sdaOe == 1'b0, "R7 sda released", sdaOe, 0);
    check(regFlat[4*8 +: 8] == 8'h04, "R7 reg4 reset", regFlat[4*8 +: 8], 8'h04);
    check(regFlat[8*8 +: 8] == 8'h0F, "R7 reg8 reset", regFlat[8*8 +: 8], 8'h0F);
    check(regFlat[5*8 +: 8] == 8'hF6, "R8 strap captured", regFlat[5*8 +: 8], 8'hF6);
    cmpOn = 1'b1; wq(20);

    blockWrite(0, 4, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b0);
    blockRead(0, 4);

    // foreign address: no ack for it or any byte after it
    cmpOn = 1'b0;
    startC();
    sendByte(8'hA4, 1'b0, 1'b0, "R1 foreign address nack");
    sendByte(8'h01, 1'b0, 1'b0, "R1 ignored until start");
    sendByte(8'h55, 1'b0, 1'b0, "R1 ignored until start");
    stopC();
    wq(4); cmpOn = 1'b1; wq(8);

    blockWrite(2, 2, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 1'b0);
    blockWrite(15, 3, '{8'h5A, 8'h6B, 8'h7C}, 1'b0);
    blockRead(14, 4);
    blockWrite(5, 1, '{8'hAA}, 1'b0);
    blockRead(5, 1);
    blockWrite(4, 1, '{8'h5C}, 1'b0);
    blockWrite(4, 1, '{8'h09}, 1'b0);
    blockWrite(4, 1, '{8'h00}, 1'b0);
    blockWrite(8, 1, '{8'h05}, 1'b1);
    blockRead(6, 5);
    blockWrite(9, 3, '{8'hC3, 8'h3C, 8'h81}, 1'b0);
    blockRead(9, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule